// File: doc/BRIEF.md
# Converter Sample Accumulator and Result Formatter

This block sits behind a converter core. Each valid strobe from the core carries one raw sample. The block cuts the sample down to the selected resolution and shows it straight away in a sample register. It also adds the sample to a running sum. Once a power-of-two number of samples has been summed, the block formats the sum into a result word and emits a one-cycle ready pulse. The accumulator and its counter then clear, ready for the next group.

There are three output formats. The first is the plain right-adjusted sum. The second is a 16-bit left-adjusted form that drops low bits when the sum is wider than 16 bits. The third is an average, rounded half-up and limited to the largest code of the selected resolution. A start request is passed on to the converter one cycle later. When free-running is enabled, the block also requests a new conversion as soon as a result completes.

Top module: `accum_scaler`

## Requirements
- R1: Only the low bits of a sample that the resolution select allows are used: select 0 keeps 12 bits, 1 keeps 13, 2 keeps 10 and 3 keeps 8. Higher input bits do not affect the sample register or the sum.
- R2: On every valid strobe, the sample register takes the masked sample in the following cycle. This holds even in the middle of a group.
- R3: With count select 0, every sample forms a result. With count select c in 1..10, a result forms after exactly 2^c samples, and no ready pulse comes before that.
- R4: Count select codes 11 to 15 behave as a single sample per result.
- R5: With scale select 0, the result is the full sum, right-adjusted.
- R6: With scale select 1, the sum is treated as a value of width w = resolution bits + count select. It is shifted so that its bit w-1 lands at bit 15. Bits that move below bit 0 are dropped, and result bits above 15 read zero.
- R7: With scale select 2, the result is (sum + 2^(c-1)) >> c, with no rounding term for c = 0. It is limited to 2^bits - 1.
- R8: Scale select 3 formats the same as scale select 0.
- R9: The ready pulse lasts one cycle and comes in the cycle after the strobe that completes a group. The result changes only together with that pulse. The next group starts from a zero sum.
- R10: A start request shows on the start output in the next cycle. When free-run is set, the start output also rises in the same cycle as the ready pulse.
- R11: While reset is held, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleValid | input | 1 | A new raw sample is on sampleIn |
| sampleIn | input | 13 | Raw converter sample |
| startReq | input | 1 | Request to start a conversion |
| resSel | input | 2 | Resolution select |
| accSel | input | 4 | Accumulation count select |
| scaleSel | input | 2 | Output format select |
| freeRun | input | 1 | Restart conversion after each result |
| sampleOut | output | 13 | Latest masked sample |
| result | output | 23 | Formatted result word |
| resultReady | output | 1 | One-cycle pulse when result updates |
| convStart | output | 1 | Start request to the converter |

## Verification
If the sample counter goes wrong, the ready pulse comes one strobe early or late within the first group. The bench checks the ready output after every strobe, so this shows within one group. A stale sum or a wrong shift amount shows in the very next result word, whichever format is selected. The bench compares each result against a model sum. Mask errors show one cycle after the strobe on the sample register. Full 1024-sample groups at the largest code exercise the widest sum and the truncating left-adjust path.

// File: rtl/accum_pkg.sv
`timescale 1ns/1ps
package accum_pkg;

  typedef enum logic [1:0] {
    SCALE_NORMAL = 2'd0,
    SCALE_LEFT   = 2'd1,
    SCALE_AVG    = 2'd2,
    SCALE_RSVD   = 2'd3
  } scaleMode_t;

  typedef struct packed {
    logic load;    // add the incoming sample
    logic finish;  // this sample closes the group
  } ctrlStrobes_t;

  function automatic logic [4:0] resBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd12;
      2'd1:    return 5'd13;
      2'd2:    return 5'd10;
      default: return 5'd8;
    endcase
  endfunction

  // Reserved count codes fold to a single sample
  function automatic logic [3:0] effCode(input logic [3:0] sel, input int maxCode);
    return (int'(sel) > maxCode) ? 4'd0 : sel;
  endfunction

endpackage

// File: rtl/accum_ctrl.sv
`timescale 1ns/1ps
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int MAX_CODE = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         startReq,
  input  logic [3:0]   accSel,
  input  logic         freeRun,
  output ctrlStrobes_t strobes,
  output logic         resultReady,
  output logic         convStart
);
  localparam int CNT_W = MAX_CODE;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastIdx;
  logic [3:0]       code;

  always_comb begin
    code           = effCode(accSel, MAX_CODE);
    lastIdx        = CNT_W'((32'd1 << code) - 32'd1);
    strobes.load   = sampleValid;
    strobes.finish = sampleValid && (count >= lastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= '0;
      resultReady <= 1'b0;
      convStart   <= 1'b0;
    end else begin
      resultReady <= strobes.finish;
      convStart   <= startReq | (freeRun & strobes.finish);
      if (strobes.finish)
        count <= '0;
      else if (strobes.load)
        count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/accum_datapath.sv
`timescale 1ns/1ps
module accum_datapath
  import accum_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int MAX_CODE = 10,
  parameter int ACC_W    = SAMPLE_W + MAX_CODE,
  parameter int LEFT_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [1:0]          resSel,
  input  logic [3:0]          accSel,
  input  logic [1:0]          scaleSel,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic [ACC_W-1:0]    result
);
  localparam int SUM_W = ACC_W + 1;

  logic [4:0]          bits, width;
  logic [3:0]          code;
  logic [SAMPLE_W-1:0] mask, masked;
  logic [ACC_W-1:0]    acc, sumNext, leftVal, scaled;
  logic [SUM_W-1:0]    half, rounded, avgShift, maxCode;
  scaleMode_t          mode;

  always_comb begin
    bits    = resBits(resSel);
    code    = effCode(accSel, MAX_CODE);
    width   = bits + {1'b0, code};
    mask    = {SAMPLE_W{1'b1}} >> (5'(SAMPLE_W) - bits);
    masked  = sampleIn & mask;
    sumNext = acc + ACC_W'(masked);
    mode    = scaleMode_t'(scaleSel);

    // left adjust: nominal width w, bit w-1 moved to bit LEFT_W-1
    if (width <= 5'(LEFT_W))
      leftVal = sumNext << (5'(LEFT_W) - width);
    else
      leftVal = sumNext >> (width - 5'(LEFT_W));

    // average: round half up, shift, clamp at resolution maximum
    half     = (code == 4'd0) ? '0 : (SUM_W'(1) << (code - 4'd1));
    rounded  = {1'b0, sumNext} + half;
    avgShift = rounded >> code;
    maxCode  = SUM_W'(mask);

    case (mode)
      SCALE_LEFT: scaled = ACC_W'(leftVal[LEFT_W-1:0]);
      SCALE_AVG:  scaled = (avgShift > maxCode) ? ACC_W'(maxCode) : ACC_W'(avgShift);
      default:    scaled = sumNext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      sampleOut <= '0;
      result    <= '0;
    end else if (strobes.load) begin
      sampleOut <= masked;
      if (strobes.finish) begin
        acc    <= '0;
        result <= scaled;
      end else begin
        acc <= sumNext;
      end
    end
  end
endmodule

// File: rtl/accum_scaler.sv
`timescale 1ns/1ps
module accum_scaler
  import accum_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int MAX_CODE = 10,
  parameter int ACC_W    = SAMPLE_W + MAX_CODE,
  parameter int LEFT_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                startReq,
  input  logic [1:0]          resSel,
  input  logic [3:0]          accSel,
  input  logic [1:0]          scaleSel,
  input  logic                freeRun,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic [ACC_W-1:0]    result,
  output logic                resultReady,
  output logic                convStart
);
  ctrlStrobes_t strobes;

  accum_ctrl #(.MAX_CODE(MAX_CODE)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .startReq    (startReq),
    .accSel      (accSel),
    .freeRun     (freeRun),
    .strobes     (strobes),
    .resultReady (resultReady),
    .convStart   (convStart)
  );

  accum_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .MAX_CODE (MAX_CODE),
    .ACC_W    (ACC_W),
    .LEFT_W   (LEFT_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleIn  (sampleIn),
    .resSel    (resSel),
    .accSel    (accSel),
    .scaleSel  (scaleSel),
    .sampleOut (sampleOut),
    .result    (result)
  );
endmodule

// File: rtl/accum_checker.sv
`timescale 1ns/1ps
module accum_checker
  import accum_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int ACC_W    = 23,
  parameter int LEFT_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic                startReq,
  input logic [1:0]          resSel,
  input logic [1:0]          scaleSel,
  input logic                freeRun,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic [ACC_W-1:0]    result,
  input logic                resultReady,
  input logic                convStart
);
  AST_SAMPLE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> ((sampleOut >> resBits($past(resSel))) == '0)); // R1

  AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    resultReady |-> $past(sampleValid)); // R9

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !resultReady |-> $stable(result)); // R9

  AST_LEFT_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (resultReady && $past(scaleSel) == SCALE_LEFT) |-> ((result >> LEFT_W) == '0)); // R6

  AST_AVG_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (resultReady && $past(scaleSel) == SCALE_AVG) |-> ((result >> resBits($past(resSel))) == '0)); // R7

  AST_FREERUN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (resultReady && $past(freeRun)) |-> convStart); // R10

  AST_START_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> convStart); // R10
endmodule

bind accum_scaler accum_checker #(
  .SAMPLE_W (SAMPLE_W),
  .ACC_W    (ACC_W),
  .LEFT_W   (LEFT_W)
) uChk (.*);

// File: tb/tb_accum_scaler.sv
`timescale 1ns/1ps
module tb_accum_scaler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [12:0] sampleIn = '0;
  logic        startReq = 1'b0;
  logic [1:0]  resSel = '0;
  logic [3:0]  accSel = '0;
  logic [1:0]  scaleSel = '0;
  logic        freeRun = 1'b0;
  logic [12:0] sampleOut;
  logic [22:0] result;
  logic        resultReady;
  logic        convStart;

  int vectors = 0;
  int fails = 0;
  longint modelSum = 0;
  int modelCnt = 0;

  accum_scaler dut (.*);

  always #4 clk = ~clk;

  function automatic int bitsOf(input int r);
    case (r)
      0: return 12;
      1: return 13;
      2: return 10;
      default: return 8;
    endcase
  endfunction

  function automatic int codeOf(input int a);
    return (a <= 10) ? a : 0;
  endfunction

  function automatic longint expResult(input longint sum, input int r, input int a, input int s);
    int b = bitsOf(r);
    int c = codeOf(a);
    int w = b + c;
    longint v;
    if (s == 1) begin
      if (w <= 16) v = (sum * (longint'(1) << (16 - w))) % 65536;
      else         v = sum / (longint'(1) << (w - 16));
    end else if (s == 2) begin
      v = (sum + ((c == 0) ? 0 : (longint'(1) << (c - 1)))) / (longint'(1) << c);
      if (v > (longint'(1) << b) - 1) v = (longint'(1) << b) - 1;
    end else begin
      v = sum;
    end
    return v;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendSample(input int v);
    int m;
    bit done;
    string tag;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = 13'(v);
    m = v & ((1 << bitsOf(int'(resSel))) - 1);
    modelSum += m;
    modelCnt++;
    done = (modelCnt == (1 << codeOf(int'(accSel))));
    @(negedge clk);
    sampleValid = 1'b0;
    chk("R1 R2 sample register", sampleOut, m);
    if (done) begin
      if (scaleSel == 2'd1)      tag = "R6 left adjusted";
      else if (scaleSel == 2'd2) tag = "R7 average";
      else if (scaleSel == 2'd3) tag = "R8 reserved scale";
      else if (accSel > 4'd10)   tag = "R4 reserved count";
      else                       tag = "R5 normal sum";
      chk("R9 ready pulse", resultReady, 1);
      chk(tag, result, expResult(modelSum, int'(resSel), int'(accSel), int'(scaleSel)));
      chk("R10 free-run start", convStart, freeRun);
      modelSum = 0;
      modelCnt = 0;
    end else begin
      chk("R3 no early ready", resultReady, 0);
    end
  endtask

  task automatic runGroup(input int r, input int a, input int s, input bit fr, input bit allMax);
    int n;
    resSel = 2'(r); accSel = 4'(a); scaleSel = 2'(s); freeRun = fr;
    n = 1 << codeOf(a);
    for (int i = 0; i < n; i++)
      sendSample(allMax ? 8191 : int'($urandom_range(0, 8191)));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    longint held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R11 reset sample", sampleOut, 0);
    chk("R11 reset result", result, 0);
    chk("R11 reset ready", resultReady, 0);
    chk("R11 reset start", convStart, 0);
    rstN = 1'b1;

    // start request forwarding
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk("R10 start forwarded", convStart, 1);
    @(negedge clk);
    chk("R10 start drops", convStart, 0);

    // directed corners
    runGroup(1, 0, 0, 0, 0);
    runGroup(3, 3, 0, 1, 0);
    runGroup(0, 4, 1, 0, 0);
    runGroup(2, 2, 2, 1, 0);
    runGroup(0, 12, 0, 0, 0);
    runGroup(0, 15, 3, 0, 0);
    runGroup(1, 5, 3, 0, 0);
    runGroup(1, 10, 0, 0, 1);
    runGroup(1, 10, 1, 1, 1);
    runGroup(1, 10, 2, 0, 1);
    runGroup(3, 10, 1, 0, 0);

    // result holds between pulses
    held = result;
    repeat (3) @(negedge clk);
    chk("R9 result stable while idle", result, held);
    chk("R9 ready low while idle", resultReady, 0);

    // random groups
    for (int g = 0; g < 40; g++)
      runGroup(int'($urandom_range(0, 3)), int'($urandom_range(0, 6)),
               int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule